// File: doc/BRIEF.md
# Drive Power-Mode State Controller

This block keeps track of the power state of a storage device that sits behind an ATA-style command interface. The device has four modes: Standby, Active, Idle and Sleep. Command strobes, soft-reset pulses, command-completion strobes and a programmable inactivity timer move the device between these modes. The command strobe carries an 8-bit opcode and an 8-bit sector-count value.

The controller drives three things:
- a clock-enable output, which is dropped while the device sleeps;
- a busy/interrupt handshake for the commands that change the mode;
- a status byte, which answers the power-mode query.

The inactivity timer counts in ticks of a parameterised prescaler. It only runs while the device is Idle. An Idle-type command arms it, using the sector count as the timeout. A count of zero disarms it.

The block executes no commands and has no register file. It contains no clock-gating cell; the enable is a plain output for a gating cell elsewhere.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After asynchronous reset the outputs are: mode Standby, clk_en 1, busy 0, irq 0, pm_status 00h, timer disarmed. Mode encoding is 0=Standby, 1=Active, 2=Idle, 3=Sleep. A one-cycle hw_rst moves the mode to Standby on the next edge, from any mode, and clears busy.
- R2: An accepted command that neither changes the power mode nor queries it moves the mode to Active on the next edge. This includes a command received while in Sleep.
- R3: cmd_done while in Active, with no other event in that cycle, moves the mode to Idle on the next edge.
- R4: soft_rst moves the mode to Standby when the device is in Sleep and to Active otherwise, on the next edge.
- R5: A sleep command (99h or E6h) ends in Sleep. clk_en is 0 exactly while the mode is Sleep.
- R6: The mode-changing commands are 97h/E3h and 95h/E1h (to Idle), 96h/E2h and 94h/E0h (to Standby), and 99h/E6h (to Sleep). Each raises busy for exactly one cycle, starting on the edge that accepts the command. On the next edge busy drops and the mode takes its target value.
- R7: irq is a one-cycle pulse that rises on the edge after the one where busy fell.
- R8: After 97h/E3h with a non-zero count N, the mode goes from Idle to Sleep on the PRESCALE×N-th edge, counted from the last restart, at which the mode was Idle and busy was 0.
- R9: 97h/E3h with a count of 0 disarms the timer, so the mode stays Idle.
- R10: Every accepted command, soft_rst, hw_rst and cmd_done restart the timer and its prescaler from zero.
- R11: The query command (98h or E5h) loads pm_status on the next edge. It loads 00h if the mode is Standby or Sleep, and FFh if the mode is Idle or Active. It never raises busy and never changes the mode.
- R12: A command presented while busy is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| hw_rst | input | 1 | Synchronous hardware reset request |
| soft_rst | input | 1 | Soft-reset pulse |
| cmd_valid | input | 1 | Command-received strobe |
| cmd_op | input | 8 | Command opcode |
| cmd_cnt | input | CNT_W | Sector-count value of the command |
| cmd_done | input | 1 | Command-finished strobe |
| mode | output | 2 | Current power mode |
| clk_en | output | 1 | Clock-gate enable |
| busy | output | 1 | Mode change in progress |
| irq | output | 1 | Completion interrupt pulse |
| pm_status | output | 8 | Power-mode query result |

## Verification
All results are registered, so each one appears a fixed number of edges after its stimulus:
- **Plain commands, soft reset, cmd_done, hw_rst and the query:** the change is visible one edge after the stimulus.
- **Mode-changing commands:** busy is visible one edge after the command, the new mode two edges after, and irq three edges after.
- **Timer expiry:** Sleep is due PRESCALE×N counted edges after the restart.

Stimulus is applied and outputs are sampled on falling edges, and every check waits exactly the number of edges listed above. The timer is run with a small prescaler. Its checks look at the edge just before expiry (still Idle) and at the expiry edge (Sleep). One timer check sends a query part-way through a countdown, so the old countdown would have expired before the sampled edge. This shows that the query restarts the timer.

// File: rtl/pwr_mode_pkg.sv
`timescale 1ns/1ps
package pwr_mode_pkg;

  typedef enum logic [1:0] {
    PM_STANDBY = 2'd0,
    PM_ACTIVE  = 2'd1,
    PM_IDLE    = 2'd2,
    PM_SLEEP   = 2'd3
  } pm_mode_e;

  localparam int OP_W = 8;

  // opcode pairs accepted by the controller
  localparam logic [OP_W-1:0] OP_QUERY_A = 8'h98;
  localparam logic [OP_W-1:0] OP_QUERY_B = 8'hE5;
  localparam logic [OP_W-1:0] OP_IDLET_A = 8'h97;
  localparam logic [OP_W-1:0] OP_IDLET_B = 8'hE3;
  localparam logic [OP_W-1:0] OP_IDLEN_A = 8'h95;
  localparam logic [OP_W-1:0] OP_IDLEN_B = 8'hE1;
  localparam logic [OP_W-1:0] OP_STBY_A  = 8'h96;
  localparam logic [OP_W-1:0] OP_STBY_B  = 8'hE2;
  localparam logic [OP_W-1:0] OP_STBYN_A = 8'h94;
  localparam logic [OP_W-1:0] OP_STBYN_B = 8'hE0;
  localparam logic [OP_W-1:0] OP_SLP_A   = 8'h99;
  localparam logic [OP_W-1:0] OP_SLP_B   = 8'hE6;

  localparam logic [7:0] STAT_LOW_PWR = 8'h00;
  localparam logic [7:0] STAT_READY   = 8'hFF;

  typedef struct packed {
    logic     is_query;
    logic     is_power;
    logic     tmr_load;
    pm_mode_e tgt;
  } pm_dec_t;

endpackage

// File: rtl/pwr_cmd_decode.sv
`timescale 1ns/1ps
module pwr_cmd_decode
  import pwr_mode_pkg::*;
(
  input  logic [OP_W-1:0] op,
  output pm_dec_t         dec
);

  always_comb begin
    dec          = '0;
    dec.tgt      = PM_ACTIVE;
    case (op)
      OP_QUERY_A, OP_QUERY_B: dec.is_query = 1'b1;
      OP_IDLET_A, OP_IDLET_B: begin
        dec.is_power = 1'b1;
        dec.tmr_load = 1'b1;
        dec.tgt      = PM_IDLE;
      end
      OP_IDLEN_A, OP_IDLEN_B: begin
        dec.is_power = 1'b1;
        dec.tgt      = PM_IDLE;
      end
      OP_STBY_A, OP_STBY_B, OP_STBYN_A, OP_STBYN_B: begin
        dec.is_power = 1'b1;
        dec.tgt      = PM_STANDBY;
      end
      OP_SLP_A, OP_SLP_B: begin
        dec.is_power = 1'b1;
        dec.tgt      = PM_SLEEP;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/pwr_idle_timer.sv
`timescale 1ns/1ps
module pwr_idle_timer #(
  parameter int PRESCALE = 1024,
  parameter int CNT_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_en,
  input  logic             restart,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             count_ok,
  output logic             expire
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic             en_q, en_d;
  logic [CNT_W-1:0] tmo_q, tmo_d;
  logic [CNT_W-1:0] tmr_q, tmr_d;
  logic             tick;

  generate
    if (PRESCALE <= 1) begin : g_no_pre
      assign tick = count_ok;
    end else begin : g_pre
      localparam int              PRE_W    = $clog2(PRESCALE);
      localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);
      logic [PRE_W-1:0] pre_q, pre_d;

      assign tick = count_ok && (pre_q == PRE_LAST);

      always_comb begin
        pre_d = pre_q;
        if (restart)       pre_d = '0;
        else if (count_ok) pre_d = tick ? '0 : pre_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
      end
    end
  endgenerate

  assign expire = en_q && tick && !restart && ((tmr_q + CNT_ONE) == tmo_q);

  always_comb begin
    en_d  = en_q;
    tmo_d = tmo_q;
    if (clr_en) begin
      en_d  = 1'b0;
      tmo_d = '0;
    end else if (load) begin
      en_d  = |load_val;
      tmo_d = load_val;
    end
  end

  always_comb begin
    tmr_d = tmr_q;
    if (restart)           tmr_d = '0;
    else if (tick && en_q) tmr_d = expire ? '0 : tmr_q + CNT_ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      tmo_q <= '0;
      tmr_q <= '0;
    end else begin
      en_q  <= en_d;
      tmo_q <= tmo_d;
      tmr_q <= tmr_d;
    end
  end

endmodule

// File: rtl/pwr_mode_fsm.sv
`timescale 1ns/1ps
module pwr_mode_fsm
  import pwr_mode_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hw_rst,
  input  logic       soft_rst,
  input  logic       cmd_valid,
  input  pm_dec_t    dec,
  input  logic       cmd_done,
  input  logic       expire,
  output pm_mode_e   mode_q,
  output logic       busy_q,
  output logic       irq_q,
  output logic       accept,
  output logic [7:0] stat_q
);

  pm_mode_e   mode_d, tgt_q, tgt_d;
  logic       busy_d, done_q;
  logic [7:0] stat_d;

  assign accept = cmd_valid && !busy_q && !hw_rst && !soft_rst;

  always_comb begin
    mode_d = mode_q;
    tgt_d  = tgt_q;
    busy_d = 1'b0;
    stat_d = stat_q;
    if (hw_rst) begin
      mode_d = PM_STANDBY;
    end else if (soft_rst) begin
      mode_d = (mode_q == PM_SLEEP) ? PM_STANDBY : PM_ACTIVE;
    end else if (busy_q) begin
      mode_d = tgt_q;
    end else if (cmd_valid) begin
      if (dec.is_query) begin
        stat_d = ((mode_q == PM_ACTIVE) || (mode_q == PM_IDLE)) ? STAT_READY : STAT_LOW_PWR;
      end else if (dec.is_power) begin
        busy_d = 1'b1;
        tgt_d  = dec.tgt;
      end else begin
        mode_d = PM_ACTIVE;
      end
    end else if (cmd_done && (mode_q == PM_ACTIVE)) begin
      mode_d = PM_IDLE;
    end else if (expire && (mode_q == PM_IDLE)) begin
      mode_d = PM_SLEEP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= PM_STANDBY;
      tgt_q  <= PM_STANDBY;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      irq_q  <= 1'b0;
      stat_q <= STAT_LOW_PWR;
    end else begin
      mode_q <= mode_d;
      tgt_q  <= tgt_d;
      busy_q <= busy_d;
      done_q <= busy_q;
      irq_q  <= done_q;
      stat_q <= stat_d;
    end
  end

endmodule

// File: rtl/pwr_mode_ctrl.sv
`timescale 1ns/1ps
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int PRESCALE = 1024,
  parameter int CNT_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hw_rst,
  input  logic             soft_rst,
  input  logic             cmd_valid,
  input  logic [7:0]       cmd_op,
  input  logic [CNT_W-1:0] cmd_cnt,
  input  logic             cmd_done,
  output logic [1:0]       mode,
  output logic             clk_en,
  output logic             busy,
  output logic             irq,
  output logic [7:0]       pm_status
);

  pm_dec_t  dec;
  pm_mode_e mode_s;
  logic     busy_s, accept, expire;
  logic     tmr_restart, tmr_load, tmr_count;

  pwr_cmd_decode u_dec (
    .op  (cmd_op),
    .dec (dec)
  );

  assign tmr_restart = accept || soft_rst || hw_rst || cmd_done;
  assign tmr_load    = accept && dec.tmr_load;
  assign tmr_count   = (mode_s == PM_IDLE) && !busy_s;

  pwr_idle_timer #(
    .PRESCALE (PRESCALE),
    .CNT_W    (CNT_W)
  ) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_en   (hw_rst),
    .restart  (tmr_restart),
    .load     (tmr_load),
    .load_val (cmd_cnt),
    .count_ok (tmr_count),
    .expire   (expire)
  );

  pwr_mode_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .hw_rst    (hw_rst),
    .soft_rst  (soft_rst),
    .cmd_valid (cmd_valid),
    .dec       (dec),
    .cmd_done  (cmd_done),
    .expire    (expire),
    .mode_q    (mode_s),
    .busy_q    (busy_s),
    .irq_q     (irq),
    .accept    (accept),
    .stat_q    (pm_status)
  );

  assign mode   = mode_s;
  assign busy   = busy_s;
  assign clk_en = (mode_s != PM_SLEEP);

endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       hw_rst,
  input logic       soft_rst,
  input logic       cmd_valid,
  input logic [7:0] cmd_op,
  input logic       cmd_done,
  input logic [1:0] mode,
  input logic       busy,
  input logic       irq
);

  logic quiet;
  assign quiet = !hw_rst && !soft_rst && !busy;

  // R1
  hw_reset_standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hw_rst |=> (mode == 2'd0) && !busy);

  // R3
  done_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && !cmd_valid && cmd_done && (mode == 2'd1)) |=> (mode == 2'd2));

  // R6
  busy_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);

  // R7
  irq_follows_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |=> irq);

  // R7
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R11
  query_keeps_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && cmd_valid && ((cmd_op == 8'h98) || (cmd_op == 8'hE5))) |=> ($stable(mode) && !busy));

endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .hw_rst    (hw_rst),
  .soft_rst  (soft_rst),
  .cmd_valid (cmd_valid),
  .cmd_op    (cmd_op),
  .cmd_done  (cmd_done),
  .mode      (mode),
  .busy      (busy),
  .irq       (irq)
);

// File: tb/pwr_mode_ctrl_tb_top.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_tb_top;

  localparam int PRE = 4;

  logic       clk = 1'b0;
  logic       rst_n, hw_rst, soft_rst, cmd_valid, cmd_done;
  logic [7:0] cmd_op, cmd_cnt;
  logic [1:0] mode;
  logic       clk_en, busy, irq;
  logic [7:0] pm_status;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  pwr_mode_ctrl #(.PRESCALE(PRE), .CNT_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .hw_rst(hw_rst), .soft_rst(soft_rst),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_cnt(cmd_cnt), .cmd_done(cmd_done),
    .mode(mode), .clk_en(clk_en), .busy(busy), .irq(irq), .pm_status(pm_status)
  );

  // {opcode, send cmd_done, expected mode, expected status}
  localparam logic [18:0] VECS [12] = '{
    {8'h98, 1'b0, 2'd0, 8'h00},
    {8'hEC, 1'b1, 2'd2, 8'h00},
    {8'hE5, 1'b0, 2'd2, 8'hFF},
    {8'h95, 1'b0, 2'd2, 8'hFF},
    {8'h96, 1'b0, 2'd0, 8'hFF},
    {8'h98, 1'b0, 2'd0, 8'h00},
    {8'hE6, 1'b0, 2'd3, 8'h00},
    {8'hE5, 1'b0, 2'd3, 8'h00},
    {8'hC8, 1'b0, 2'd1, 8'h00},
    {8'hE5, 1'b0, 2'd1, 8'hFF},
    {8'hE0, 1'b0, 2'd0, 8'hFF},
    {8'h99, 1'b0, 2'd3, 8'hFF}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] op, input logic [7:0] cnt);
    cmd_op = op; cmd_cnt = cnt; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic pulse_soft();
    soft_rst = 1'b1; @(negedge clk); soft_rst = 1'b0;
  endtask

  task automatic pulse_done();
    cmd_done = 1'b1; @(negedge clk); cmd_done = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; hw_rst = 1'b0; soft_rst = 1'b0; cmd_valid = 1'b0;
    cmd_done = 1'b0; cmd_op = 8'h00; cmd_cnt = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset mode", 8'(mode), 8'd0);
    chk("R1 reset clk_en", 8'(clk_en), 8'd1);
    chk("R1 reset busy", 8'(busy), 8'd0);
    chk("R1 reset irq", 8'(irq), 8'd0);
    chk("R1 reset status", pm_status, 8'h00);

    for (int i = 0; i < 12; i++) begin
      send(VECS[i][18:11], 8'd0);
      repeat (3) @(negedge clk);
      if (VECS[i][10]) pulse_done();
      chk($sformatf("R2 R3 R6 R11 vector %0d mode", i), 8'(mode), 8'(VECS[i][9:8]));
      chk($sformatf("R11 vector %0d status", i), pm_status, VECS[i][7:0]);
      chk($sformatf("R5 vector %0d clk_en", i), 8'(clk_en), (VECS[i][9:8] == 2'd3) ? 8'd0 : 8'd1);
    end

    // R1: hardware reset out of Sleep
    hw_rst = 1'b1; @(negedge clk); hw_rst = 1'b0;
    chk("R1 hw_rst from sleep mode", 8'(mode), 8'd0);
    chk("R1 hw_rst clk_en", 8'(clk_en), 8'd1);

    // R6 R7: busy/irq timing of an idle command with count 0
    send(8'h97, 8'd0);
    chk("R6 busy after accept", 8'(busy), 8'd1);
    chk("R6 mode held while busy", 8'(mode), 8'd0);
    @(negedge clk);
    chk("R6 busy dropped", 8'(busy), 8'd0);
    chk("R6 mode target", 8'(mode), 8'd2);
    chk("R7 irq not yet", 8'(irq), 8'd0);
    @(negedge clk);
    chk("R7 irq pulse", 8'(irq), 8'd1);
    @(negedge clk);
    chk("R7 irq single", 8'(irq), 8'd0);

    // R9: disarmed timer keeps Idle
    repeat (40) @(negedge clk);
    chk("R9 timer disarmed", 8'(mode), 8'd2);

    // R12: a command while busy is ignored
    send(8'h95, 8'd0);
    chk("R12 busy set", 8'(busy), 8'd1);
    send(8'h99, 8'd0);
    repeat (3) @(negedge clk);
    chk("R12 sleep ignored while busy", 8'(mode), 8'd2);

    // R8 R5: timer expiry with count 2
    send(8'h97, 8'd2);
    repeat (2 * PRE) @(negedge clk);
    chk("R8 idle before expiry", 8'(mode), 8'd2);
    @(negedge clk);
    chk("R8 sleep at expiry", 8'(mode), 8'd3);
    chk("R5 clk_en low in sleep", 8'(clk_en), 8'd0);

    // R4 R3: soft reset paths
    pulse_soft();
    chk("R4 soft reset from sleep", 8'(mode), 8'd0);
    pulse_soft();
    chk("R4 soft reset from standby", 8'(mode), 8'd1);
    pulse_done();
    chk("R3 done to idle", 8'(mode), 8'd2);

    // R10: query part-way restarts the countdown
    send(8'h97, 8'd3);
    repeat (7) @(negedge clk);
    send(8'hE5, 8'd0);
    chk("R11 status in idle", pm_status, 8'hFF);
    repeat (3 * PRE - 1) @(negedge clk);
    chk("R10 restart delays expiry", 8'(mode), 8'd2);
    @(negedge clk);
    chk("R10 expiry after restart", 8'(mode), 8'd3);

    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule